// File: doc/BRIEF.md
# Staged Transmit Bring-up and Status Controller

This block is the global control and status unit for the transmit side of an audio serial port. Software writes a request word naming five sub-blocks to release: the high-frequency clock divider, the bit clock divider, the serializer, the transmit engine and the frame generator. An internal stage machine releases them strictly one at a time, in a fixed order. It holds the transmit engine and the frame generator back until the transmit buffer has received its first word. Reading the control word returns the enables as actually applied, so software can poll until every bit it set reads back as one.

The block also tracks whether the transmit buffer holds a word. It raises a DMA request while the buffer is empty, and it flags an underrun when a slot begins with nothing to send. It keeps a status word whose event bits stay set until software writes a one to them. An interrupt line follows the underrun flag when that interrupt is enabled. Serial shifting and clock division sit outside the block. They appear here only as enable outputs and as incoming slot and frame strobes.

Stage machine states, in order: `ST_IDLE` (all held in reset), `ST_HFCLK` (high-frequency divider running), `ST_BITCLK` (bit clock divider running), `ST_SERIAL` (serializer released, waiting for the first word), `ST_ENGINE` (transmit engine released) and `ST_RUN` (frame generator released). The machine moves through the states as follows:
- Forward transitions: `ST_IDLE→ST_HFCLK` on request bit 9, `ST_HFCLK→ST_BITCLK` on bit 8, `ST_BITCLK→ST_SERIAL` on bit 10, `ST_SERIAL→ST_ENGINE` on bit 11 with the buffer loaded, and `ST_ENGINE→ST_RUN` on bit 12.
- Fallback transition: from any state, the machine drops to the highest stage whose own request bit, and every earlier request bit, is still set.

Top module: `txstage_ctl`

## Requirements
- R1: After reset all five enables, `dma_req` and `irq` are low, and both the control word (address 0) and the status word (address 1) read zero.
- R2: Control bits are at these positions: bit 9 is the high-frequency divider, bit 8 is the bit clock divider and bit 10 is the serializer. The first applied stage appears one cycle after the write edge, and each further stage appears one cycle after the one before it. A read of address 0 returns the applied enables at those positions, and never the requested value.
- R3: The transmit engine (bit 11) is released only after a buffer write has marked the buffer loaded. The frame generator (bit 12) follows the engine one cycle later.
- R4: Status bit 5 reads one while the serializer is released and the buffer is empty. It reads zero from the cycle after a buffer write. Writes to bit 5 have no effect on it.
- R5: `dma_req` is high exactly when status bit 5 is one and bit 0 of the DMA control register (address 3) is zero.
- R6: A slot strobe while the engine runs and the buffer is empty sets status bit 0 (underrun). A slot strobe while the buffer is full consumes the word and sets no underrun.
- R7: Event inputs set these sticky status bits: sync error (bit 1), clock fail (bit 2), DM slot (bit 3), last slot (bit 4), start of frame (bit 6) and DMA error (bit 7). Start of frame is recorded only while the frame generator is released. Bit 8 is the OR of bits 0, 1, 2 and 7.
- R8: `irq` is high exactly when bit 0 of the interrupt enable register (address 2) and status bit 0 are both one.
- R9: Writing a one to a status bit clears it, writing a zero leaves it, and writing 0x1FF clears every sticky bit.
- R10: Writing zero to the control word drops all five enables in the cycle after the write edge.
- R11: Clearing the request bits of later stages drops only those stages, one cycle after the write edge, and leaves the earlier stages running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 interrupt enable, 3 DMA control |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` (combinational) |
| buf_wr | input | 1 | A word was written into the transmit buffer |
| slot_start | input | 1 | Strobe: a transmit slot begins |
| frame_start | input | 1 | Strobe: a frame begins |
| ev_sync_err | input | 1 | Strobe: frame sync error |
| ev_clk_fail | input | 1 | Strobe: clock failure |
| ev_dm_slot | input | 1 | Strobe: DM slot seen |
| ev_last_slot | input | 1 | Strobe: last slot of frame |
| ev_dma_err | input | 1 | Strobe: DMA error |
| hf_clk_en | output | 1 | High-frequency divider released |
| bit_clk_en | output | 1 | Bit clock divider released |
| ser_en | output | 1 | Serializer released |
| eng_en | output | 1 | Transmit engine released |
| fs_en | output | 1 | Frame generator released |
| dma_req | output | 1 | DMA data request |
| irq | output | 1 | Underrun interrupt |

## Verification
The full-request write is issued from idle, and the control readback is sampled after every single cycle. This shows whether stages arrive one at a time and in order, and whether the readback reports applied state rather than the request. Holding the buffer empty for several cycles shows that the engine gate waits for the load. The single buffer write that follows shows the one-cycle and two-cycle release of the engine and the frame generator.

Slot strobes are applied first with the buffer full and then with it empty, which separates word consumption from underrun. A frame strobe given before and after the frame generator runs tests the gating of the start-of-frame bit. Two clear patterns are used: a single underrun bit written while a sync error is also pending, and a full 0x1FF write. Together they tell a per-bit clear from a blanket clear, and show that the summary bit follows its remaining contributors. A partial request clear is compared with a zero write to check the fallback depth.

// File: rtl/txstage_pkg.sv
package txstage_pkg;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT   = 2'd1;
    localparam logic [ADDR_W-1:0] A_IRQEN  = 2'd2;
    localparam logic [ADDR_W-1:0] A_DMACTL = 2'd3;

    // stage order used internally
    localparam int NSTAGE = 5;
    localparam int SG_HF  = 0;
    localparam int SG_BIT = 1;
    localparam int SG_SER = 2;
    localparam int SG_ENG = 3;
    localparam int SG_FRM = 4;

    // control word bit positions
    localparam int CB_BIT = 8;
    localparam int CB_HF  = 9;
    localparam int CB_SER = 10;
    localparam int CB_ENG = 11;
    localparam int CB_FRM = 12;

    // status word bit positions
    localparam int STAT_W  = 9;
    localparam int SB_UNDR = 0;
    localparam int SB_SYNC = 1;
    localparam int SB_CKF  = 2;
    localparam int SB_DMS  = 3;
    localparam int SB_LAST = 4;
    localparam int SB_NEED = 5;
    localparam int SB_SOF  = 6;
    localparam int SB_DMAE = 7;
    localparam int SB_ERR  = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HFCLK  = 3'd1,
        ST_BITCLK = 3'd2,
        ST_SERIAL = 3'd3,
        ST_ENGINE = 3'd4,
        ST_RUN    = 3'd5
    } stage_e;

    // highest stage whose request bit and all earlier ones are set
    function automatic stage_e stage_ceiling(input logic [NSTAGE-1:0] req);
        logic [2:0] n;
        logic       hold;
        n    = '0;
        hold = 1'b1;
        for (int i = 0; i < NSTAGE; i++) begin
            hold = hold & req[i];
            if (hold) n = n + 3'd1;
        end
        return stage_e'(n);
    endfunction

endpackage

// File: rtl/txstage_fsm.sv
module txstage_fsm
    import txstage_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSTAGE-1:0] req,
    input  logic              loaded,
    output logic [NSTAGE-1:0] en
);

    stage_e state_q, state_d, ceil;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ceil    = stage_ceiling(req);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req[SG_HF])            state_d = ST_HFCLK;
            ST_HFCLK:  if (req[SG_BIT])           state_d = ST_BITCLK;
            ST_BITCLK: if (req[SG_SER])           state_d = ST_SERIAL;
            ST_SERIAL: if (req[SG_ENG] && loaded) state_d = ST_ENGINE;
            ST_ENGINE: if (req[SG_FRM])           state_d = ST_RUN;
            ST_RUN:                               state_d = ST_RUN;
            default:                              state_d = ST_IDLE;
        endcase
        if (state_q > ceil) state_d = ceil;
    end

    always_comb begin
        en = '0;
        unique case (state_q)
            ST_IDLE:   en = 5'b00000;
            ST_HFCLK:  en = 5'b00001;
            ST_BITCLK: en = 5'b00011;
            ST_SERIAL: en = 5'b00111;
            ST_ENGINE: en = 5'b01111;
            ST_RUN:    en = 5'b11111;
            default:   en = 5'b00000;
        endcase
    end

endmodule

// File: rtl/txstage_buf.sv
module txstage_buf (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_on,
    input  logic eng_on,
    input  logic buf_wr,
    input  logic slot_start,
    output logic full,
    output logic underrun
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     full <= 1'b0;
        else if (!ser_on)               full <= 1'b0;
        else if (buf_wr)                full <= 1'b1;
        else if (slot_start && eng_on)  full <= 1'b0;
    end

    assign underrun = slot_start && eng_on && !full;

endmodule

// File: rtl/txstage_status.sv
module txstage_status
    import txstage_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    input  logic              need,
    output logic [STAT_W-1:0] word
);

    localparam logic [STAT_W-1:0] LIVE_MASK =
        (STAT_W'(1) << SB_NEED) | (STAT_W'(1) << SB_ERR);
    localparam logic [STAT_W-1:0] STICKY_MASK = ~LIVE_MASK;
    localparam logic [STAT_W-1:0] ERR_MASK =
        (STAT_W'(1) << SB_UNDR) | (STAT_W'(1) << SB_SYNC) |
        (STAT_W'(1) << SB_CKF)  | (STAT_W'(1) << SB_DMAE);

    logic [STAT_W-1:0] sticky_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= ((sticky_q & ~clr_vec) | set_vec) & STICKY_MASK;
    end

    always_comb begin
        word         = sticky_q;
        word[SB_NEED] = need;
        word[SB_ERR]  = |(sticky_q & ERR_MASK);
    end

endmodule

// File: rtl/txstage_ctl.sv
module txstage_ctl
    import txstage_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              buf_wr,
    input  logic              slot_start,
    input  logic              frame_start,
    input  logic              ev_sync_err,
    input  logic              ev_clk_fail,
    input  logic              ev_dm_slot,
    input  logic              ev_last_slot,
    input  logic              ev_dma_err,
    output logic              hf_clk_en,
    output logic              bit_clk_en,
    output logic              ser_en,
    output logic              eng_en,
    output logic              fs_en,
    output logic              dma_req,
    output logic              irq
);

    logic [NSTAGE-1:0] req_q;
    logic [NSTAGE-1:0] en;
    logic [REG_W-1:0]  irq_en_q;
    logic [REG_W-1:0]  dma_ctl_q;
    logic              buf_full;
    logic              underrun;
    logic              need;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] stat_word;

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q     <= '0;
            irq_en_q  <= '0;
            dma_ctl_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: begin
                    req_q[SG_HF]  <= reg_wdata[CB_HF];
                    req_q[SG_BIT] <= reg_wdata[CB_BIT];
                    req_q[SG_SER] <= reg_wdata[CB_SER];
                    req_q[SG_ENG] <= reg_wdata[CB_ENG];
                    req_q[SG_FRM] <= reg_wdata[CB_FRM];
                end
                A_IRQEN:  irq_en_q  <= reg_wdata;
                A_DMACTL: dma_ctl_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    txstage_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_q),
        .loaded (buf_full),
        .en     (en)
    );

    txstage_buf buf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_on     (en[SG_SER]),
        .eng_on     (en[SG_ENG]),
        .buf_wr     (buf_wr),
        .slot_start (slot_start),
        .full       (buf_full),
        .underrun   (underrun)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SB_UNDR] = underrun;
        set_vec[SB_SYNC] = ev_sync_err;
        set_vec[SB_CKF]  = ev_clk_fail;
        set_vec[SB_DMS]  = ev_dm_slot;
        set_vec[SB_LAST] = ev_last_slot;
        set_vec[SB_SOF]  = frame_start && en[SG_FRM];
        set_vec[SB_DMAE] = ev_dma_err;
        clr_vec = (reg_wr && reg_addr == A_STAT) ? reg_wdata[STAT_W-1:0] : '0;
    end

    assign need = en[SG_SER] && !buf_full;

    txstage_status stat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .need    (need),
        .word    (stat_word)
    );

    assign hf_clk_en  = en[SG_HF];
    assign bit_clk_en = en[SG_BIT];
    assign ser_en     = en[SG_SER];
    assign eng_en     = en[SG_ENG];
    assign fs_en      = en[SG_FRM];
    assign dma_req    = stat_word[SB_NEED] && !dma_ctl_q[0];
    assign irq        = irq_en_q[0] && stat_word[SB_UNDR];

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[CB_HF]  = en[SG_HF];
                reg_rdata[CB_BIT] = en[SG_BIT];
                reg_rdata[CB_SER] = en[SG_SER];
                reg_rdata[CB_ENG] = en[SG_ENG];
                reg_rdata[CB_FRM] = en[SG_FRM];
            end
            A_STAT:   reg_rdata[STAT_W-1:0] = stat_word;
            A_IRQEN:  reg_rdata = irq_en_q;
            A_DMACTL: reg_rdata = dma_ctl_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txstage_chk.sv
module txstage_chk
    import txstage_pkg::*;
#(
    parameter int REG_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSTAGE-1:0] en,
    input logic              buf_full,
    input logic              dma_req,
    input logic              dma_dis,
    input logic              irq,
    input logic              irq_en0,
    input logic              slot_start,
    input logic [STAT_W-1:0] stat_word,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata
);

    p_bitclk_after_hf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en[SG_BIT]) |-> $past(en[SG_HF]));

    p_ser_after_bitclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en[SG_SER]) |-> $past(en[SG_BIT]));

    p_engine_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en[SG_ENG]) |-> $past(buf_full));

    p_frame_after_engine_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en[SG_FRM]) |-> $past(en[SG_ENG]));

    p_dma_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (en[SG_SER] && !buf_full && !dma_dis));

    p_underrun_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && en[SG_ENG] && !buf_full) |=> stat_word[SB_UNDR]);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en0 && stat_word[SB_UNDR]));

    p_zero_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[CB_FRM:CB_BIT] == '0)
            |-> ##2 (en == '0));

endmodule

bind txstage_ctl txstage_chk #(.REG_W(REG_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .buf_full   (buf_full),
    .dma_req    (dma_req),
    .dma_dis    (dma_ctl_q[0]),
    .irq        (irq),
    .irq_en0    (irq_en_q[0]),
    .slot_start (slot_start),
    .stat_word  (stat_word),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata)
);

// File: tb/txstage_ctl_tb_top.sv
`timescale 1ns/1ps
module txstage_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        buf_wr = 1'b0, slot_start = 1'b0, frame_start = 1'b0;
    logic        ev_sync_err = 1'b0, ev_clk_fail = 1'b0, ev_dm_slot = 1'b0;
    logic        ev_last_slot = 1'b0, ev_dma_err = 1'b0;
    logic        hf_clk_en, bit_clk_en, ser_en, eng_en, fs_en, dma_req, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txstage_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_wr(buf_wr),
        .slot_start(slot_start), .frame_start(frame_start),
        .ev_sync_err(ev_sync_err), .ev_clk_fail(ev_clk_fail),
        .ev_dm_slot(ev_dm_slot), .ev_last_slot(ev_last_slot),
        .ev_dma_err(ev_dma_err), .hf_clk_en(hf_clk_en),
        .bit_clk_en(bit_clk_en), .ser_en(ser_en), .eng_en(eng_en),
        .fs_en(fs_en), .dma_req(dma_req), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int ens();
        return {27'd0, fs_en, eng_en, ser_en, bit_clk_en, hf_clk_en};
    endfunction

    task automatic t_reset();
        logic [15:0] d;
        rd(2'd0, d); check("R1 control", d, 0);
        rd(2'd1, d); check("R1 status", d, 0);
        check("R1 enables", ens(), 0);
        check("R1 dma_req/irq", {dma_req, irq}, 0);
    endtask

    task automatic t_bringup();
        logic [15:0] d;
        wr(2'd0, 16'h1F00);
        rd(2'd0, d); check("R2 nothing applied yet", d, 16'h0000);
        step(); rd(2'd0, d); check("R2 hf stage", d, 16'h0200);
        check("R2 hf enable only", ens(), 5'b00001);
        step(); rd(2'd0, d); check("R2 bit clock stage", d, 16'h0300);
        step(); rd(2'd0, d); check("R2 serializer stage", d, 16'h0700);
        repeat (4) step();
        rd(2'd0, d); check("R3 held for load", d, 16'h0700);
        check("R3 engine off", eng_en, 0);
        rd(2'd1, d); check("R4 data needed", d, 16'h0020);
        check("R5 dma_req on", dma_req, 1);
    endtask

    task automatic t_dma_gate();
        logic [15:0] d;
        wr(2'd3, 16'h0001);
        check("R5 dma disabled", dma_req, 0);
        rd(2'd1, d); check("R5 need still set", d, 16'h0020);
        wr(2'd3, 16'h0000);
        check("R5 dma re-enabled", dma_req, 1);
        wr(2'd1, 16'h0020);
        rd(2'd1, d); check("R4 need ignores write", d, 16'h0020);
    endtask

    task automatic t_frame_gate();
        logic [15:0] d;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        rd(2'd1, d); check("R7 frame ignored before release", d, 16'h0020);
    endtask

    task automatic t_load();
        logic [15:0] d;
        @(negedge clk); buf_wr = 1'b1;
        @(negedge clk); buf_wr = 1'b0;
        rd(2'd1, d); check("R4 need cleared", d, 16'h0000);
        check("R5 dma_req off", dma_req, 0);
        rd(2'd0, d); check("R3 engine not yet", d, 16'h0700);
        step(); rd(2'd0, d); check("R3 engine released", d, 16'h0F00);
        step(); rd(2'd0, d); check("R3 frame released", d, 16'h1F00);
        check("R3 all enables", ens(), 5'b11111);
    endtask

    task automatic t_frame_seen();
        logic [15:0] d;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        rd(2'd1, d); check("R7 frame start recorded", d, 16'h0040);
        wr(2'd1, 16'h0040);
        rd(2'd1, d); check("R9 frame bit cleared", d, 16'h0000);
    endtask

    task automatic t_underrun();
        logic [15:0] d;
        @(negedge clk); slot_start = 1'b1;
        @(negedge clk); slot_start = 1'b0;
        rd(2'd1, d); check("R6 word consumed, no underrun", d, 16'h0020);
        check("R5 dma_req after consume", dma_req, 1);
        @(negedge clk); slot_start = 1'b1;
        @(negedge clk); slot_start = 1'b0;
        rd(2'd1, d); check("R6 underrun with summary", d, 16'h0121);
        check("R8 irq masked", irq, 0);
        wr(2'd2, 16'h0001);
        check("R8 irq raised", irq, 1);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        @(negedge clk); ev_sync_err = 1'b1;
        @(negedge clk); ev_sync_err = 1'b0;
        rd(2'd1, d); check("R7 sync error bit", d, 16'h0123);
        wr(2'd1, 16'h0001);
        rd(2'd1, d); check("R9 single clear keeps summary", d, 16'h0122);
        check("R8 irq follows underrun", irq, 0);
        @(negedge clk); ev_clk_fail = 1'b1; ev_last_slot = 1'b1;
        @(negedge clk); ev_clk_fail = 1'b0; ev_last_slot = 1'b0;
        rd(2'd1, d); check("R7 clock fail and last slot", d, 16'h0136);
        wr(2'd1, 16'h01FF);
        rd(2'd1, d); check("R9 clear all", d, 16'h0020);
    endtask

    task automatic t_partial();
        logic [15:0] d;
        wr(2'd0, 16'h0700);
        step();
        rd(2'd0, d); check("R11 fallback to serializer", d, 16'h0700);
        check("R11 earlier stages kept", ens(), 5'b00111);
    endtask

    task automatic t_stop();
        logic [15:0] d;
        wr(2'd0, 16'h0000);
        step();
        check("R10 all enables dropped", ens(), 0);
        rd(2'd0, d); check("R10 control reads zero", d, 0);
        rd(2'd1, d); check("R10 need gone", d, 0);
        check("R10 dma_req off", dma_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bringup();
        t_dma_gate();
        t_frame_gate();
        t_load();
        t_frame_seen();
        t_underrun();
        t_w1c();
        t_partial();
        t_stop();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule